// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins, with a small word-wide register interface. Software uses it to set the direction and output value of each pin and to read back the pin levels. It also gives each pin an alternate-function select bit, which is passed to the pad multiplexer outside the block. Every pin can raise an interrupt. For each pin, software chooses edge detection (rising or falling) or level detection (active-high or active-low).

Each pin input passes through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one cycle earlier. A qualifying event sets a sticky pending bit, and a level condition keeps setting its bit for as long as it holds. Software clears all pending bits at once by writing zero to the pending register. To detect both edges, software flips the edge polarity after each event. The bank gives one summary interrupt: the OR of the pending bits whose mask bit is 0.

Register addresses (4-bit `bus_addr`) are as follows:

| Address | Register | Access |
|---|---|---|
| 0 | pin direction | read/write |
| 1 | output value | read/write |
| 2 | alternate-function select | read/write |
| 3 | pin level | read-only |
| 4 | interrupt mask | read/write |
| 5 | detect mode | read/write |
| 6 | edge polarity | read/write |
| 7 | level polarity | read/write |
| 8 | pending | read, write zero to clear |

Reads from any other address return zero. Writes to other addresses are ignored.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, except two. The mask register and the level-polarity register read 0xFFFF. `bank_irq` is low.
- R2: Direction (address 0), output (address 1) and alternate-function (address 2) read back the value last written. `pin_oe`, `pin_out` and `alt_sel` show those registers one cycle after the write. In the direction register, a 1 means the pin is an output.
- R3: The pin-level register (address 3) returns `pin_in` as seen through two flops. A change on `pin_in` is visible after the second rising edge. Writes to address 3 are ignored.
- R4: With detect-mode bit 1 (edge) and edge-polarity bit 1, a 0-to-1 transition on the pin sets pending bit i at the third rising edge after the pin changes. The bit stays set after the pin returns to 0.
- R5: With detect-mode bit 1 and edge-polarity bit 0, only a 1-to-0 transition sets the pending bit. A 0-to-1 transition leaves it clear.
- R6: With detect-mode bit 0 (level), pending bit i is set while the pin is high (level-polarity 1) or low (level-polarity 0). The bit stays set after the condition ends.
- R7: Writing 0x0000 to the pending register (address 8) clears every pending bit. Writing any non-zero value there leaves the pending bits unchanged.
- R8: If a qualifying event occurs in the same cycle as a clearing write, that event's pending bit is set after the write.
- R9: `bank_irq` is the OR of the pending bits whose mask bit is 0. A mask bit of 1 blocks the pin from `bank_irq`, but the pin's pending bit still sets and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Output value for each pin |
| pin_oe | output | 16 | Output enable for each pin (1 = drive) |
| alt_sel | output | 16 | Alternate-function select for each pin |
| bank_irq | output | 1 | Summary interrupt of the bank |

## Verification
The timing of each result is as follows:
- A register write is taken at one rising edge and is visible on the read data and on the output ports straight after that edge.
- A change on a pin shows in the pin-level register after the second rising edge.
- An event caused by a pin change reaches the pending register, and `bank_irq`, at the third rising edge.
- A change of polarity or mode that makes a level condition true sets the pending bit at the second edge after the write.

The bench drives every input on the falling edge and samples after the edge on which a result is due. For the latency checks it also samples after the edge just before, where the old value must still be present. In the same-cycle case, the clearing write is timed to land exactly on the third edge after the pin change.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the GPIO interrupt bank.
// Assumes a 4-bit word address on the register interface.
package gpio_irq_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR   = 4'd0,
        RA_OUT   = 4'd1,
        RA_ALT   = 4'd2,
        RA_LEVEL = 4'd3,
        RA_MASK  = 4'd4,
        RA_MODE  = 4'd5,
        RA_EPOL  = 4'd6,
        RA_LPOL  = 4'd7,
        RA_PEND  = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
// Multi-stage synchroniser for asynchronous pin inputs.
// Assumes the inputs are single-bit independent signals (no bus coherency needed).
module gpio_irq_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [STAGES-1:0][W-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                // Further stage reduces metastability risk.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin event detector: edge (rising/falling) or level (high/low).
// Assumes lvl_now is already synchronous to clk.
module gpio_irq_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_now,
    input  logic [W-1:0] mode_edge,
    input  logic [W-1:0] edge_rise,
    input  logic [W-1:0] lvl_high,
    output logic [W-1:0] evt
);
    logic [W-1:0] lvl_prev_q;

    // Hold the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev_q <= '0;
        else        lvl_prev_q <= lvl_now;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            logic rise_w, fall_w, lvl_hit_w, edge_hit_w;
            assign rise_w     = lvl_now[i] & ~lvl_prev_q[i];
            assign fall_w     = ~lvl_now[i] & lvl_prev_q[i];
            assign edge_hit_w = edge_rise[i] ? rise_w : fall_w;
            assign lvl_hit_w  = lvl_high[i] ? lvl_now[i] : ~lvl_now[i];
            assign evt[i]     = mode_edge[i] ? edge_hit_w : lvl_hit_w;
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_regs.sv
// Register file of the bank: configuration registers, sticky pending
// register and read-data multiplexer.
// Assumes single-cycle writes and a combinational read path.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      lvl_now,
    input  logic [W-1:0]      evt,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      alt_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      mode_q,
    output logic [W-1:0]      epol_q,
    output logic [W-1:0]      lpol_q,
    output logic [W-1:0]      pend_q
);
    logic clr_w;
    assign clr_w = bus_wr && (bus_addr == RA_PEND) && (bus_wdata == '0);

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            alt_q  <= '0;
            mask_q <= '1;
            mode_q <= '0;
            epol_q <= '0;
            lpol_q <= '1;
        end else if (bus_wr) begin
            case (bus_addr)
                RA_DIR:  dir_q  <= bus_wdata;
                RA_OUT:  out_q  <= bus_wdata;
                RA_ALT:  alt_q  <= bus_wdata;
                RA_MASK: mask_q <= bus_wdata;
                RA_MODE: mode_q <= bus_wdata;
                RA_EPOL: epol_q <= bus_wdata;
                RA_LPOL: lpol_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Sticky pending bits; a new event outranks a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (clr_w ? '0 : pend_q) | evt;
    end

    // Read-data selection.
    always_comb begin
        case (bus_addr)
            RA_DIR:   bus_rdata = dir_q;
            RA_OUT:   bus_rdata = out_q;
            RA_ALT:   bus_rdata = alt_q;
            RA_LEVEL: bus_rdata = lvl_now;
            RA_MASK:  bus_rdata = mask_q;
            RA_MODE:  bus_rdata = mode_q;
            RA_EPOL:  bus_rdata = epol_q;
            RA_LPOL:  bus_rdata = lpol_q;
            RA_PEND:  bus_rdata = pend_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// Top of one GPIO bank with per-pin interrupt detection and a summary
// interrupt. Assumes pin_in is asynchronous and the bus is synchronous.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  alt_sel,
    output logic              bank_irq
);
    logic [NPINS-1:0] lvl_w, evt_w;
    logic [NPINS-1:0] dir_w, out_w, alt_w, mask_w, mode_w, epol_w, lpol_w, pend_w;

    gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (lvl_w)
    );

    gpio_irq_detect #(.W(NPINS)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_now   (lvl_w),
        .mode_edge (mode_w),
        .edge_rise (epol_w),
        .lvl_high  (lpol_w),
        .evt       (evt_w)
    );

    gpio_irq_regs #(.W(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lvl_now   (lvl_w),
        .evt       (evt_w),
        .dir_q     (dir_w),
        .out_q     (out_w),
        .alt_q     (alt_w),
        .mask_q    (mask_w),
        .mode_q    (mode_w),
        .epol_q    (epol_w),
        .lpol_q    (lpol_w),
        .pend_q    (pend_w)
    );

    assign pin_out  = out_w;
    assign pin_oe   = dir_w;
    assign alt_sel  = alt_w;
    assign bank_irq = |(pend_w & ~mask_w);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Assertion checker for gpio_irq_bank, attached by bind.
// Assumes the default two-stage synchroniser.
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pin_in,
    input logic [W-1:0]      pin_oe,
    input logic              bank_irq,
    input logic [W-1:0]      pend_q,
    input logic [W-1:0]      mask_q,
    input logic [W-1:0]      evt,
    input logic [W-1:0]      lvl
);
    logic [1:0] since_rst_q;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1) && (pend_q == '0) && !bank_irq);

    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_DIR) |=> pin_oe == $past(bus_wdata));

    a_r3_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd2) |-> lvl == $past(pin_in, 2));

    a_r4_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == RA_PEND && bus_wdata == '0)
        |=> (pend_q & $past(pend_q)) == $past(pend_q));

    a_r7_nonzero_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_PEND && bus_wdata != '0)
        |=> pend_q == ($past(pend_q) | $past(evt)));

    a_r8_clear_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_PEND && bus_wdata == '0)
        |=> pend_q == $past(evt));

    a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !bank_irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .bank_irq  (bank_irq),
    .pend_q    (pend_w),
    .mask_q    (mask_w),
    .evt       (evt_w),
    .lvl       (lvl_w)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, alt_sel;
    logic        bank_irq;

    int n_checks = 0;
    int n_errors = 0;

    localparam logic [3:0] A_DIR = 4'd0, A_OUT = 4'd1, A_ALT = 4'd2, A_LVL = 4'd3,
                           A_MSK = 4'd4, A_MOD = 4'd5, A_EP = 4'd6, A_LP = 4'd7,
                           A_PND = 4'd8;

    always #5 clk = ~clk;

    gpio_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel), .bank_irq(bank_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Expected pending bits after settling on a, clearing, then moving to b.
    function automatic logic [15:0] exp_pend(input logic [15:0] a, input logic [15:0] b,
                                             input logic [15:0] md, input logic [15:0] ep,
                                             input logic [15:0] lp);
        logic [15:0] lvl_part, edge_part;
        lvl_part  = ~md & ((lp & (a | b)) | (~lp & (~a | ~b)));
        edge_part = md & ((ep & ~a & b) | (~ep & a & ~b));
        return lvl_part | edge_part;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        logic [15:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_DIR, v); check("R1 dir", v, 16'h0000);
        rd(A_OUT, v); check("R1 out", v, 16'h0000);
        rd(A_ALT, v); check("R1 alt", v, 16'h0000);
        rd(A_MSK, v); check("R1 mask", v, 16'hFFFF);
        rd(A_MOD, v); check("R1 mode", v, 16'h0000);
        rd(A_EP,  v); check("R1 epol", v, 16'h0000);
        rd(A_LP,  v); check("R1 lpol", v, 16'hFFFF);
        rd(A_PND, v); check("R1 pend", v, 16'h0000);
        check("R1 irq", {15'd0, bank_irq}, 16'h0000);

        // R2 plain registers and ports
        wr(A_DIR, 16'hA5C3); wr(A_OUT, 16'h1234); wr(A_ALT, 16'h0F0F);
        rd(A_DIR, v); check("R2 dir rb", v, 16'hA5C3);
        rd(A_OUT, v); check("R2 out rb", v, 16'h1234);
        rd(A_ALT, v); check("R2 alt rb", v, 16'h0F0F);
        check("R2 pin_oe", pin_oe, 16'hA5C3);
        check("R2 pin_out", pin_out, 16'h1234);
        check("R2 alt_sel", alt_sel, 16'h0F0F);

        // R3 two-edge latency and read-only level register
        @(negedge clk); pin_in = 16'h8001;
        @(negedge clk); rd(A_LVL, v); check("R3 level after 1 edge", v, 16'h0000);
        @(negedge clk); rd(A_LVL, v); check("R3 level after 2 edges", v, 16'h8001);
        wr(A_LVL, 16'hFFFF);
        rd(A_LVL, v); check("R3 level write ignored", v, 16'h8001);
        @(negedge clk); pin_in = 16'h0000;
        wait_neg(3);

        // R4 rising edge on pin 0, R5 falling edge on pin 1
        wr(A_MOD, 16'h0003); wr(A_EP, 16'h0001); wr(A_LP, 16'hFFFF);
        wr(A_PND, 16'h0000);
        rd(A_PND, v); check("R4 pend clear before", v, 16'h0000);
        @(negedge clk); pin_in = 16'h0001;
        @(negedge clk); @(negedge clk); rd(A_PND, v); check("R4 not yet at edge 2", v, 16'h0000);
        @(negedge clk); rd(A_PND, v); check("R4 rise at edge 3", v, 16'h0001);
        @(negedge clk); pin_in = 16'h0000;
        wait_neg(4); rd(A_PND, v); check("R4 sticky after pin low", v, 16'h0001);
        @(negedge clk); pin_in = 16'h0002;
        wait_neg(4); rd(A_PND, v); check("R5 rise ignored", v, 16'h0001);
        @(negedge clk); pin_in = 16'h0000;
        wait_neg(4); rd(A_PND, v); check("R5 fall sets", v, 16'h0003);

        // R7 non-zero write keeps, zero write clears
        wr(A_PND, 16'h0003);
        rd(A_PND, v); check("R7 nonzero no effect", v, 16'h0003);
        wr(A_PND, 16'h0000);
        rd(A_PND, v); check("R7 zero clears", v, 16'h0000);

        // R6 level detect on pin 2
        wr(A_MOD, 16'h0000); wr(A_LP, 16'hFFFF);
        @(negedge clk); pin_in = 16'h0004;
        wait_neg(4); rd(A_PND, v); check("R6 high level sets", v, 16'h0004);
        @(negedge clk); pin_in = 16'h0000;
        wait_neg(4); rd(A_PND, v); check("R6 remains after level ends", v, 16'h0004);
        wr(A_PND, 16'h0000);
        rd(A_PND, v); check("R6 cleared when idle", v, 16'h0000);
        wr(A_LP, 16'hFFFB);
        @(negedge clk); rd(A_PND, v); check("R6 low level sets", v, 16'h0004);
        wr(A_LP, 16'hFFFF);
        wr(A_PND, 16'h0000);

        // R8 event in the same cycle as clear; pin 0 pending first
        wr(A_MOD, 16'h0021); wr(A_EP, 16'h0021);
        @(negedge clk); pin_in = 16'h0001;
        wait_neg(4); rd(A_PND, v); check("R8 setup pin0", v, 16'h0001);
        @(negedge clk); pin_in = 16'h0021;
        @(negedge clk);
        wr(A_PND, 16'h0000);
        rd(A_PND, v); check("R8 event beats clear", v, 16'h0020);

        // R9 masking
        check("R9 masked irq low", {15'd0, bank_irq}, 16'h0000);
        wr(A_MSK, 16'hFFDF);
        check("R9 unmasked irq high", {15'd0, bank_irq}, 16'h0001);
        wr(A_MSK, 16'hFFFE);
        check("R9 other pin unmasked irq low", {15'd0, bank_irq}, 16'h0000);
        rd(A_PND, v); check("R9 pending kept while masked", v, 16'h0020);

        // Random configurations and pin patterns (R4 R5 R6 R9)
        for (int it = 0; it < 40; it++) begin
            logic [15:0] a, b, md, ep, lp, mk, e;
            a = 16'($urandom); b = 16'($urandom); md = 16'($urandom);
            ep = 16'($urandom); lp = 16'($urandom); mk = 16'($urandom);
            wr(A_MSK, 16'hFFFF);
            @(negedge clk); pin_in = a;
            wr(A_MOD, md); wr(A_EP, ep); wr(A_LP, lp);
            wait_neg(4);
            wr(A_PND, 16'h0000);
            rd(A_PND, v);
            check("R6 random level after clear", v, ~md & ((lp & a) | (~lp & ~a)));
            @(negedge clk); pin_in = b;
            wait_neg(4);
            e = exp_pend(a, b, md, ep, lp);
            rd(A_PND, v); check("R4 R5 R6 random pending", v, e);
            wr(A_MSK, mk);
            check("R9 random irq", {15'd0, bank_irq}, {15'd0, |(e & ~mk)});
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule